// File: doc/BRIEF.md
# SCI Interrupt Steering Unit

This block routes the power-management system control interrupt (SCI) onto exactly one pin of a 24-pin interrupt vector. Software picks the pin through a three-bit select field held in an ACPI control byte; the same byte carries an enable bit. That enable bit decides whether the power-management I/O base register is passed on or forced to zero. Pins 0 to 15 belong to the legacy controller side and pins 16 to 23 to the APIC side.

The SCI request arrives as a multi-bit source value that is reduced to one level: any nonzero value means active. The selected pin follows that level one clock later.

When the target is moved while the SCI is driving a pin, the old pin is released for one full cycle before the new pin is raised, so downstream edge logic never sees two pins at once. Select codes outside the legal set are ignored for targeting. The enable bit in the same write still takes effect.

Top module: `sci_steer`

## Requirements
- R1: Select codes (control byte bits [2:0]) map to pins as follows: 3'b000 to 9, 3'b001 to 10, 3'b010 to 11, 3'b100 to 20 and 3'b101 to 21. A legal write updates `sci_tgt_o` and sets `sci_tgt_valid_o` at the write's clock edge.
- R2: A write with a reserved code (3'b011, 3'b110, 3'b111) leaves `sci_tgt_o` and `sci_tgt_valid_o` unchanged. Its enable bit (bit 7) is still stored.
- R3: After reset, `sci_tgt_valid_o`, `apic_side_o`, `pm_base_o` and `sci_pin_o` are all zero. The reset control byte holds a reserved code with the enable bit clear.
- R4: With a valid target, a nonzero `sci_src_i` raises pin `sci_tgt_o` of `sci_pin_o` one clock later. A zero `sci_src_i` clears it one clock later.
- R5: A legal write that changes the target while a pin is driven gives one cycle with all pins low, then the new pin high one cycle after that.
- R6: A target change while no pin is driven updates `sci_tgt_o` and leaves every pin low.
- R7: `pm_base_o` equals the stored base ANDed with the address mask (default 32'h0000_FF80) when the enable bit is set, and zero otherwise. It updates at the edge of the write to either register.
- R8: `apic_side_o` is high exactly when the target is valid and 16 or above.
- R9: At most one pin is high. A pin never switches directly to another pin. A steady SCI level with no writes leaves `sci_pin_o` unchanged, and this includes a write of the same target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sci_src_i | input | 8 | SCI request; any nonzero value means active |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 1 | Register select: 0 control byte, 1 PM base |
| wr_data_i | input | 32 | Write data; control uses bit 7 (enable) and bits [2:0] (select) |
| sci_tgt_o | output | 5 | Current SCI pin number |
| sci_tgt_valid_o | output | 1 | A legal target has been chosen |
| apic_side_o | output | 1 | Target lies on the APIC side (16 or above) |
| pm_base_o | output | 32 | Effective PM I/O base |
| sci_pin_o | output | 24 | Per-pin SCI assert vector |

## Verification
All eight select codes are written in turn with the SCI idle. This separates the legal mappings from the reserved codes, which must leave the previous target in place. The retarget sequence is then run with the SCI active to two kinds of destination: a different pin, which must produce the one-cycle gap, and the same pin or a reserved code, which must produce no glitch. Idle retargeting checks that no pin is raised. The PM base is written with the enable bit clear, set through a legal code, and set through a reserved code, which shows that masking and gating are independent of the select decode.

// File: rtl/sci_steer_pkg.sv
package sci_steer_pkg;
    localparam int NUM_PINS   = 24;
    localparam int TGT_W      = $clog2(NUM_PINS);
    localparam int APIC_BASE  = 16;
    localparam int DATA_W     = 32;
    localparam int SRC_W      = 8;
    localparam int SEL_W      = 3;
    localparam int EN_BIT     = 7;

    typedef struct packed {
        logic             legal;
        logic [TGT_W-1:0] tgt;
    } sel_res_t;

    function automatic sel_res_t sel_decode(input logic [SEL_W-1:0] code);
        sel_res_t r;
        r.legal = 1'b1;
        case (code)
            3'b000:  r.tgt = TGT_W'(9);
            3'b001:  r.tgt = TGT_W'(10);
            3'b010:  r.tgt = TGT_W'(11);
            3'b100:  r.tgt = TGT_W'(20);
            3'b101:  r.tgt = TGT_W'(21);
            default: begin
                r.tgt   = '0;
                r.legal = 1'b0;
            end
        endcase
        return r;
    endfunction

    typedef struct packed {
        logic [TGT_W-1:0]  tgt;
        logic              valid;
        logic              en;
        logic [DATA_W-1:0] base;
        logic [DATA_W-1:0] pm_eff;
        logic              level;
        logic              blank;
        logic              apic;
    } steer_st_t;
endpackage

// File: rtl/sci_code_decode.sv
module sci_code_decode
    import sci_steer_pkg::*;
(
    input  logic [SEL_W-1:0] code_i,
    output logic [TGT_W-1:0] tgt_o,
    output logic             legal_o
);
    sel_res_t res;

    always_comb begin
        res     = sel_decode(code_i);
        tgt_o   = res.tgt;
        legal_o = res.legal;
    end
endmodule

// File: rtl/sci_pin_fanout.sv
module sci_pin_fanout
    import sci_steer_pkg::*;
(
    input  logic [TGT_W-1:0]    tgt_i,
    input  logic                on_i,
    output logic [NUM_PINS-1:0] pins_o
);
    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        assign pins_o[p] = on_i && (tgt_i == TGT_W'(p));
    end
endmodule

// File: rtl/sci_steer.sv
module sci_steer
    import sci_steer_pkg::*;
#(
    parameter logic [DATA_W-1:0] PM_ADDR_MASK = 32'h0000_FF80,
    parameter logic [7:0]        CTRL_RST     = 8'h07,
    parameter logic [DATA_W-1:0] PMBASE_RST   = 32'h0000_0001
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [SRC_W-1:0]    sci_src_i,
    input  logic                wr_en_i,
    input  logic                wr_sel_i,
    input  logic [DATA_W-1:0]   wr_data_i,
    output logic [TGT_W-1:0]    sci_tgt_o,
    output logic                sci_tgt_valid_o,
    output logic                apic_side_o,
    output logic [DATA_W-1:0]   pm_base_o,
    output logic [NUM_PINS-1:0] sci_pin_o
);
    localparam sel_res_t RST_SEL = sel_decode(CTRL_RST[SEL_W-1:0]);

    steer_st_t           st_d, st_q;
    logic [NUM_PINS-1:0] pins_d, pins_q;
    logic [TGT_W-1:0]    dec_tgt;
    logic                dec_legal;
    logic                ctrl_wr, base_wr;

    assign ctrl_wr = wr_en_i && !wr_sel_i;
    assign base_wr = wr_en_i && wr_sel_i;

    sci_code_decode u_dec (
        .code_i  (wr_data_i[SEL_W-1:0]),
        .tgt_o   (dec_tgt),
        .legal_o (dec_legal)
    );

    always_comb begin
        st_d       = st_q;
        st_d.level = |sci_src_i;
        st_d.blank = 1'b0;
        if (ctrl_wr) begin
            st_d.en = wr_data_i[EN_BIT];
            if (dec_legal) begin
                // release a driven pin for one cycle before moving
                if ((|pins_q) && (dec_tgt != st_q.tgt)) begin
                    st_d.blank = 1'b1;
                end
                st_d.tgt   = dec_tgt;
                st_d.valid = 1'b1;
            end
        end
        if (base_wr) begin
            st_d.base = wr_data_i;
        end
        st_d.pm_eff = st_d.en ? (st_d.base & PM_ADDR_MASK) : '0;
        st_d.apic   = st_d.valid && (st_d.tgt >= TGT_W'(APIC_BASE));
    end

    sci_pin_fanout u_fan (
        .tgt_i  (st_d.tgt),
        .on_i   (st_d.level && st_d.valid && !st_d.blank),
        .pins_o (pins_d)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.tgt    <= RST_SEL.tgt;
            st_q.valid  <= RST_SEL.legal;
            st_q.en     <= CTRL_RST[EN_BIT];
            st_q.base   <= PMBASE_RST;
            st_q.pm_eff <= CTRL_RST[EN_BIT] ? (PMBASE_RST & PM_ADDR_MASK) : '0;
            st_q.level  <= 1'b0;
            st_q.blank  <= 1'b0;
            st_q.apic   <= RST_SEL.legal && (RST_SEL.tgt >= TGT_W'(APIC_BASE));
            pins_q      <= '0;
        end else begin
            st_q   <= st_d;
            pins_q <= pins_d;
        end
    end

    assign sci_tgt_o       = st_q.tgt;
    assign sci_tgt_valid_o = st_q.valid;
    assign apic_side_o     = st_q.apic;
    assign pm_base_o       = st_q.pm_eff;
    assign sci_pin_o       = pins_q;

    // R9
    pin_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sci_pin_o));

    // R5
    no_direct_hop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sci_pin_o != '0) |=> (sci_pin_o == '0) || (sci_pin_o == $past(sci_pin_o)));

    // R2
    reserved_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && !dec_legal) |=> $stable(sci_tgt_o) && $stable(sci_tgt_valid_o));

    // R7
    pm_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pm_base_o & ~PM_ADDR_MASK) == '0);

    // R4
    invalid_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sci_tgt_valid_o |-> (sci_pin_o == '0));

    // R8
    apic_side_chk: assert property (@(posedge clk) disable iff (!rst_n)
        apic_side_o |-> sci_tgt_valid_o && (sci_tgt_o >= TGT_W'(APIC_BASE)));

    // R9
    steady_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en_i && !st_q.blank && ((|sci_src_i) == st_q.level)) |=> $stable(sci_pin_o));
endmodule

// File: tb/sci_steer_test.sv
module sci_steer_test;
    import sci_steer_pkg::*;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic [SRC_W-1:0]    sci_src_i = '0;
    logic                wr_en_i = 1'b0;
    logic                wr_sel_i = 1'b0;
    logic [DATA_W-1:0]   wr_data_i = '0;
    logic [TGT_W-1:0]    sci_tgt_o;
    logic                sci_tgt_valid_o;
    logic                apic_side_o;
    logic [DATA_W-1:0]   pm_base_o;
    logic [NUM_PINS-1:0] sci_pin_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    sci_steer uut (
        .clk             (clk),
        .rst_n           (rst_n),
        .sci_src_i       (sci_src_i),
        .wr_en_i         (wr_en_i),
        .wr_sel_i        (wr_sel_i),
        .wr_data_i       (wr_data_i),
        .sci_tgt_o       (sci_tgt_o),
        .sci_tgt_valid_o (sci_tgt_valid_o),
        .apic_side_o     (apic_side_o),
        .pm_base_o       (pm_base_o),
        .sci_pin_o       (sci_pin_o)
    );

    task automatic chk(input string tag, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    function automatic longint pin(input int n);
        return longint'(1) << n;
    endfunction

    task automatic wr_ctrl(input logic [7:0] b);
        wr_en_i = 1'b1; wr_sel_i = 1'b0; wr_data_i = {24'h0, b};
        @(negedge clk);
        wr_en_i = 1'b0;
    endtask

    task automatic wr_base(input logic [31:0] v);
        wr_en_i = 1'b1; wr_sel_i = 1'b1; wr_data_i = v;
        @(negedge clk);
        wr_en_i = 1'b0;
    endtask

    task automatic t_reset();
        chk("R3 valid", sci_tgt_valid_o, 0);
        chk("R3 pins", sci_pin_o, 0);
        chk("R3 pm base", pm_base_o, 0);
        chk("R3 apic", apic_side_o, 0);
    endtask

    task automatic t_decode();
        wr_ctrl(8'h03); chk("R2 reserved at start keeps invalid", sci_tgt_valid_o, 0);
        wr_ctrl(8'h00); chk("R1 code0 tgt", sci_tgt_o, 9); chk("R1 code0 valid", sci_tgt_valid_o, 1);
        chk("R8 pic side", apic_side_o, 0);
        wr_ctrl(8'h03); chk("R2 code3 keeps 9", sci_tgt_o, 9); chk("R2 valid kept", sci_tgt_valid_o, 1);
        wr_ctrl(8'h01); chk("R1 code1 tgt", sci_tgt_o, 10);
        wr_ctrl(8'h02); chk("R1 code2 tgt", sci_tgt_o, 11);
        wr_ctrl(8'h06); chk("R2 code6 keeps 11", sci_tgt_o, 11);
        wr_ctrl(8'h04); chk("R1 code4 tgt", sci_tgt_o, 20); chk("R8 apic side", apic_side_o, 1);
        wr_ctrl(8'h05); chk("R1 code5 tgt", sci_tgt_o, 21);
        wr_ctrl(8'h07); chk("R2 code7 keeps 21", sci_tgt_o, 21);
        chk("R6 no pin while idle", sci_pin_o, 0);
    endtask

    task automatic t_level();
        wr_ctrl(8'h00);
        sci_src_i = 8'h40;
        @(negedge clk); chk("R4 pin9 raised", sci_pin_o, pin(9));
        sci_src_i = 8'h01;
        repeat (3) @(negedge clk);
        chk("R9 steady level holds pin", sci_pin_o, pin(9));
        sci_src_i = 8'h00;
        @(negedge clk); chk("R4 pin9 cleared", sci_pin_o, 0);
    endtask

    task automatic t_retarget_active();
        sci_src_i = 8'h80;
        @(negedge clk); chk("R4 pin9 again", sci_pin_o, pin(9));
        wr_ctrl(8'h04);
        chk("R5 gap cycle", sci_pin_o, 0);
        chk("R5 target moved", sci_tgt_o, 20);
        @(negedge clk); chk("R5 new pin", sci_pin_o, pin(20));
        wr_ctrl(8'h04);
        chk("R9 same target no glitch", sci_pin_o, pin(20));
        @(negedge clk); chk("R9 same target held", sci_pin_o, pin(20));
        wr_ctrl(8'h07);
        chk("R2 reserved while active", sci_pin_o, pin(20));
        @(negedge clk); chk("R2 reserved still held", sci_pin_o, pin(20));
        sci_src_i = 8'h00;
        @(negedge clk); chk("R4 pin20 cleared", sci_pin_o, 0);
    endtask

    task automatic t_retarget_idle();
        wr_ctrl(8'h02);
        chk("R6 idle target", sci_tgt_o, 11);
        chk("R6 idle pins", sci_pin_o, 0);
        @(negedge clk); chk("R6 idle pins later", sci_pin_o, 0);
    endtask

    task automatic t_pm();
        wr_base(32'h1234_5678); chk("R7 disabled gives zero", pm_base_o, 0);
        wr_ctrl(8'h82); chk("R7 enabled masked", pm_base_o, 32'h0000_5600);
        wr_base(32'hFFFF_FFFF); chk("R7 all ones masked", pm_base_o, 32'h0000_FF80);
        wr_ctrl(8'h02); chk("R7 disable clears", pm_base_o, 0);
        wr_ctrl(8'h87); chk("R2 reserved still sets enable", pm_base_o, 32'h0000_FF80);
        chk("R2 reserved keeps 11", sci_tgt_o, 11);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_decode();
        t_level();
        t_retarget_active();
        t_retarget_idle();
        t_pm();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule